// File: doc/BRIEF.md
# Single-Wire Byte Exchange Multiplexer

This block is the host end of a point-to-point serial link that uses one wire per peripheral. When the host writes a byte, the block runs one transaction. Eight bit slots go out and eight bits come back, most significant bit first, so each transaction is a byte swap in the way an SPI exchange is. The block has only one transceiver. A bidirectional line multiplexer connects it to one of three peripheral lines, and a select field that software writes chooses the line.

Each line is open-drain. The block never drives a line high. It only asserts a drive-low enable, and an external pull-up takes the wire high when the line is released. Every slot has three parts. First the host pulls the line low for a short start window. Next the host holds the line low, or releases it, to send its own data bit. Finally the host releases the line, and the peripheral may pull it low. The host samples the line at a fixed count inside this last window. A recovery gap follows the eighth slot. After the gap the received byte is committed and ready returns high. Software polls ready to find out when the exchange is complete. All timings are counts of system clock cycles.

Top module: `swx_xcvr_top`

## Requirements
- R1: Reset state: after reset, ready is 1, rx_byte is 0x00, sel_cur is 0 and no line_pull bit is set.
- R2: A xfer_wr pulse while ready is 1 starts a transaction. Ready then reads 0 for exactly N_BITS*SLOT_CYC + RECOV_CYC cycles, and the first of those cycles is the cycle after the write.
- R3: Each slot starts with line_pull high for START_CYC cycles. A data bit of 0 keeps line_pull high until HOST_END_CYC cycles into the slot. A data bit of 1 releases the line after the start window. Bits go out most significant bit first.
- R4: The host samples the selected line SAMPLE_AT cycles into each slot, after a SYNC_STAGES-flop synchronizer. A low line is a 0 bit and a high line is a 1 bit. The eight samples are packed most significant bit first into rx_byte.
- R5: At most one line_pull bit is ever set, and only the bit whose index equals sel_cur. No bit is set while ready is 1.
- R6: A sel_wr pulse while ready is 0 leaves sel_cur unchanged.
- R7: A sel_wr pulse whose value is N_LINES or greater leaves sel_cur unchanged. A smaller value loads sel_cur in the cycle after the pulse.
- R8: A xfer_wr pulse while ready is 0 changes neither the byte being sent nor the length of the transaction.
- R9: rx_byte changes only in the cycle where ready returns to 1. It holds its old value throughout a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_wr | input | 1 | Data register write strobe; starts an exchange when ready |
| xfer_byte | input | 8 | Byte to send |
| sel_wr | input | 1 | Select field write strobe |
| sel_val | input | 2 | Requested line index |
| ready | output | 1 | 1 when idle; 0 while an exchange is running |
| rx_byte | output | 8 | Last received byte |
| sel_cur | output | 2 | Current line selection |
| line_in | input | 3 | Sensed level of each line (pulled up when released) |
| line_pull | output | 3 | Drive-low enable per line; 0 means high-impedance |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a running exchange, in the same cycle as a sample or a slot boundary. Such a write must not disturb the line being driven or the byte being sent. The bench includes reactive peripheral models, one per line, that decode the host's bits and answer on their own wire. Random transactions then inject data and select writes at a random busy cycle, and directed cases pin down the all-zero and all-one bytes and an out-of-range select.

// File: rtl/swx_pkg.sv
package swx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SLOT  = 2'd1,
    ST_RECOV = 2'd2
  } swx_state_e;

  // Whether the host pulls the wire low at slot offset c for data bit b.
  function automatic logic host_pulls_low(input int unsigned c, input logic b,
                                          input int unsigned start_len,
                                          input int unsigned host_end);
    return (c < start_len) || (!b && (c < host_end));
  endfunction

  // Number of cycles ready stays low for one exchange.
  function automatic int unsigned xfer_busy_cycles(input int unsigned nbits,
                                                   input int unsigned slot_len,
                                                   input int unsigned recov_len);
    return nbits * slot_len + recov_len;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swx_slot_timer.sv
module swx_slot_timer
  import swx_pkg::*;
#(
  parameter int N_BITS    = 8,
  parameter int SLOT_CYC  = 20,
  parameter int RECOV_CYC = 6,
  parameter int SAMPLE_AT = 13,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output swx_state_e       state,
  output logic [CNT_W-1:0] cnt,
  output logic             slot_start,
  output logic             slot_end,
  output logic             sample_now,
  output logic             xfer_done
);
  localparam int BIT_W = (N_BITS > 1) ? $clog2(N_BITS) : 1;
  localparam logic [CNT_W-1:0] SLOT_LAST  = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] SAMP_PT    = CNT_W'(SAMPLE_AT);
  localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(N_BITS - 1);

  logic [BIT_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_SLOT;
            cnt     <= '0;
            bit_idx <= '0;
          end
        end
        ST_SLOT: begin
          if (cnt == SLOT_LAST) begin
            cnt <= '0;
            if (bit_idx == BIT_LAST) state <= ST_RECOV;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RECOV: begin
          if (cnt == RECOV_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign slot_start = (state == ST_SLOT) && (cnt == '0);
  assign slot_end   = (state == ST_SLOT) && (cnt == SLOT_LAST);
  assign sample_now = (state == ST_SLOT) && (cnt == SAMP_PT);
  assign xfer_done  = (state == ST_RECOV) && (cnt == RECOV_LAST);

endmodule

// File: rtl/swx_shifter.sv
module swx_shifter #(
  parameter int N_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [N_BITS-1:0] load_val,
  input  logic              advance,
  input  logic              sample_now,
  input  logic              rx_bit,
  input  logic              commit,
  output logic              tx_msb,
  output logic [N_BITS-1:0] rx_data
);
  logic [N_BITS-1:0] tx_sr;
  logic [N_BITS-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= load_val;
    end else if (advance) begin
      tx_sr <= {tx_sr[N_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0;
    end else if (sample_now) begin
      rx_sr <= {rx_sr[N_BITS-2:0], rx_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
    end else if (commit) begin
      rx_data <= rx_sr;
    end
  end

  assign tx_msb = tx_sr[N_BITS-1];

endmodule

// File: rtl/swx_line_mux.sv
module swx_line_mux #(
  parameter int N_LINES     = 3,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic               pull,
  input  logic [N_LINES-1:0] line_in,
  output logic [N_LINES-1:0] line_pull,
  output logic               rx_bit
);
  logic [N_LINES-1:0] sync_out;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign line_pull[i] = pull && (sel == SEL_W'(i));

    if (SYNC_STAGES > 1) begin : g_multi
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-2:0], line_in[i]};
      end
      assign sync_out[i] = chain[SYNC_STAGES-1];
    end else begin : g_single
      logic chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= line_in[i];
      end
      assign sync_out[i] = chain;
    end
  end

  always_comb begin
    rx_bit = 1'b1;
    for (int i = 0; i < N_LINES; i++) begin
      if (sel == SEL_W'(i)) rx_bit = sync_out[i];
    end
  end

endmodule

// File: rtl/swx_xcvr_top.sv
module swx_xcvr_top
  import swx_pkg::*;
#(
  parameter int N_LINES      = 3,
  parameter int N_BITS       = 8,
  parameter int SLOT_CYC     = 20,
  parameter int START_CYC    = 2,
  parameter int HOST_END_CYC = 8,
  parameter int SAMPLE_AT    = 13,
  parameter int RECOV_CYC    = 6,
  parameter int SYNC_STAGES  = 2,
  localparam int SEL_W       = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_wr,
  input  logic [N_BITS-1:0]  xfer_byte,
  input  logic               sel_wr,
  input  logic [SEL_W-1:0]   sel_val,
  output logic               ready,
  output logic [N_BITS-1:0]  rx_byte,
  output logic [SEL_W-1:0]   sel_cur,
  input  logic [N_LINES-1:0] line_in,
  output logic [N_LINES-1:0] line_pull
);
  localparam int CNT_W = $clog2(max_u(SLOT_CYC, RECOV_CYC) + 1);

  swx_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             slot_start;
  logic             slot_end;
  logic             sample_now;
  logic             xfer_done;
  logic             start_xfer;
  logic             tx_msb;
  logic             rx_bit;
  logic             host_pull;
  logic             sel_ok;

  assign ready      = (state == ST_IDLE);
  assign start_xfer = xfer_wr && ready;
  assign sel_ok     = ({1'b0, sel_val} < (SEL_W + 1)'(N_LINES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_cur <= '0;
    else if (sel_wr && ready && sel_ok) sel_cur <= sel_val;
  end

  swx_slot_timer #(
    .N_BITS(N_BITS), .SLOT_CYC(SLOT_CYC), .RECOV_CYC(RECOV_CYC),
    .SAMPLE_AT(SAMPLE_AT), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_xfer),
    .state(state), .cnt(cnt),
    .slot_start(slot_start), .slot_end(slot_end),
    .sample_now(sample_now), .xfer_done(xfer_done)
  );

  swx_shifter #(.N_BITS(N_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(start_xfer), .load_val(xfer_byte),
    .advance(slot_end), .sample_now(sample_now), .rx_bit(rx_bit),
    .commit(xfer_done), .tx_msb(tx_msb), .rx_data(rx_byte)
  );

  assign host_pull = (state == ST_SLOT) &&
                     host_pulls_low(int'(cnt), tx_msb, START_CYC, HOST_END_CYC);

  swx_line_mux #(
    .N_LINES(N_LINES), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .sel(sel_cur), .pull(host_pull),
    .line_in(line_in), .line_pull(line_pull), .rx_bit(rx_bit)
  );

endmodule

// File: rtl/swx_xcvr_checks.sv
module swx_xcvr_checks #(
  parameter int N_LINES  = 3,
  parameter int SEL_W    = 2,
  parameter int N_BITS   = 8,
  parameter int BUSY_CYC = 166
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic [SEL_W-1:0]   sel_cur,
  input logic [N_BITS-1:0]  rx_byte,
  input logic [N_LINES-1:0] line_pull,
  input logic               slot_start,
  input logic               sample_now,
  input logic               xfer_done
);
  int unsigned busy_cnt;
  int unsigned samp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= 0;
      samp_cnt <= 0;
    end else begin
      busy_cnt <= ready ? 0 : busy_cnt + 1;
      if (ready) samp_cnt <= 0;
      else if (sample_now) samp_cnt <= samp_cnt + 1;
    end
  end

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (busy_cnt == BUSY_CYC));

  a_r3_slot_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> (line_pull != '0));

  a_r4_eight_samples: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (samp_cnt == N_BITS));

  a_r5_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_pull));

  a_r5_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pull & ~(N_LINES'(1) << sel_cur)) == '0);

  a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (line_pull == '0));

  a_r6_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(sel_cur));

  a_r9_rx_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $rose(ready));

endmodule

bind swx_xcvr_top swx_xcvr_checks #(
  .N_LINES(N_LINES), .SEL_W(SEL_W), .N_BITS(N_BITS),
  .BUSY_CYC(swx_pkg::xfer_busy_cycles(N_BITS, SLOT_CYC, RECOV_CYC))
) u_checks (
  .clk(clk), .rst_n(rst_n), .ready(ready), .sel_cur(sel_cur),
  .rx_byte(rx_byte), .line_pull(line_pull), .slot_start(slot_start),
  .sample_now(sample_now), .xfer_done(xfer_done)
);

// File: tb/sim_swx_xcvr_top.sv
`timescale 1ns/1ps
module sim_swx_xcvr_top;
  localparam int NL = 3, NB = 8, SLOT = 20, STARTC = 2, HEND = 8, SAMP = 13, RECOV = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xfer_wr = 1'b0, sel_wr = 1'b0;
  logic [7:0] xfer_byte = '0;
  logic [1:0] sel_val = '0;
  logic ready;
  logic [7:0] rx_byte;
  logic [1:0] sel_cur;
  logic [NL-1:0] line_in, line_pull, periph_low = '0;

  int vectors = 0, fails = 0;

  always #4 clk = ~clk;

  assign line_in = ~(line_pull | periph_low);

  swx_xcvr_top u0 (
    .clk(clk), .rst_n(rst_n), .xfer_wr(xfer_wr), .xfer_byte(xfer_byte),
    .sel_wr(sel_wr), .sel_val(sel_val), .ready(ready), .rx_byte(rx_byte),
    .sel_cur(sel_cur), .line_in(line_in), .line_pull(line_pull)
  );

  // Peripheral models, one per line.
  int pc [NL];
  int slot_k [NL];
  logic [7:0] reply [NL];
  logic [7:0] got [NL];
  logic [NL-1:0] prev_pull = '0;

  initial for (int i = 0; i < NL; i++) begin
    pc[i] = -1000; slot_k[i] = -1; reply[i] = 8'hFF; got[i] = '0;
  end

  function automatic int busy_expect();
    return NB * SLOT + RECOV;
  endfunction

  function automatic logic periph_pulls(input int c, input logic b);
    return (c > HEND) && (c < SLOT - 1) && !b;
  endfunction

  always @(negedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (ready) slot_k[i] = -1;
      if (line_pull[i] && !prev_pull[i]) begin
        pc[i] = 0;
        slot_k[i] = slot_k[i] + 1;
      end else if (pc[i] >= 0) begin
        pc[i] = pc[i] + 1;
      end
      if (pc[i] == (STARTC + HEND) / 2)
        got[i] = {got[i][6:0], ~line_pull[i]};
      if (slot_k[i] >= 0 && slot_k[i] < NB)
        periph_low[i] <= periph_pulls(pc[i], reply[i][7 - slot_k[i]]);
      else
        periph_low[i] <= 1'b0;
    end
    prev_pull = line_pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [1:0] sel_model = '0;

  task automatic set_sel(input logic [1:0] v);
    @(negedge clk); sel_wr = 1'b1; sel_val = v;
    @(negedge clk); sel_wr = 1'b0;
    if (v < NL) sel_model = v;
    chk("R7 select write", sel_cur, sel_model);
  endtask

  // One exchange; poke_at < 0 means no writes while busy.
  task automatic run_xfer(input logic [7:0] d, input logic [7:0] rep, input int poke_at);
    int busy_n = 0;
    bit rx_moved = 0, stray = 0;
    logic [7:0] rx_before;
    logic [1:0] s = sel_model;
    reply[s] = rep;
    rx_before = rx_byte;
    @(negedge clk); xfer_wr = 1'b1; xfer_byte = d;
    @(negedge clk); xfer_wr = 1'b0;
    while (!ready && busy_n < 1000) begin
      if (rx_byte !== rx_before) rx_moved = 1;
      if ((line_pull & ~(3'b001 << s)) != 0) stray = 1;
      if (busy_n == poke_at) begin
        xfer_wr = 1'b1; xfer_byte = ~d; sel_wr = 1'b1; sel_val = s + 2'd1;
      end else begin
        xfer_wr = 1'b0; sel_wr = 1'b0;
      end
      @(negedge clk);
      busy_n++;
    end
    xfer_wr = 1'b0; sel_wr = 1'b0;
    chk("R2 busy length", busy_n, busy_expect());
    chk("R3 byte seen by peripheral", got[s], d);
    chk("R4 received byte", rx_byte, rep);
    chk("R5 unselected lines released", stray, 0);
    chk("R9 rx held while busy", rx_moved, 0);
    chk("R5 released when idle", line_pull, 0);
    if (poke_at >= 0) begin
      chk("R6 select ignored while busy", sel_cur, s);
      chk("R8 data write ignored while busy", got[s], d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", ready, 1);
    chk("R1 rx after reset", rx_byte, 0);
    chk("R1 select after reset", sel_cur, 0);
    chk("R1 lines after reset", line_pull, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready out of reset", ready, 1);

    run_xfer(8'h00, 8'hFF, -1);
    run_xfer(8'hFF, 8'h00, -1);
    set_sel(2'd2);
    run_xfer(8'hA5, 8'h3C, -1);
    set_sel(2'd3);
    chk("R7 out-of-range select kept", sel_cur, 2'd2);
    run_xfer(8'h81, 8'h7E, 0);
    set_sel(2'd1);
    run_xfer(8'h5A, 8'hC3, busy_expect() - 1);
    run_xfer(8'h12, 8'h34, SAMP);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] sv = 2'($urandom_range(0, 3));
      logic [7:0] dv = 8'($urandom);
      logic [7:0] rv = 8'($urandom);
      int pk = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, busy_expect() - 1)) : -1;
      set_sel(sv);
      run_xfer(dv, rv, pk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule